// File: doc/BRIEF.md
# Register-to-Peripheral Command Bridge

The bridge is a slave on a 64-bit register bus that turns a single host write into one transfer on a 32-bit peripheral master port. The host packs the whole transfer into one 64-bit command word: direction, transfer size, a 24-bit byte address and the 32-bit write data. The bridge accepts the command when it is idle and holds a request, with the command fields, on the peripheral port. The request ends when the peripheral acknowledges, when it answers with an error-acknowledge, or when an internal cycle limit runs out.

The host follows progress by polling one status word. Its upper half carries the busy flag, the read-data-valid flag and the error flags. Its lower half returns the data of the most recent successful read. A second status word keeps sticky copies of the error flags. Writing the top bit of the status register clears the errors. Writing the top bit of the reset register aborts the transfer in flight and clears all flags.

All register positions below are given in the 64-bit word; "upper bit k" is bit 32+k.

Top module: `rb_pbus_bridge`

## Requirements
- R1: After reset the peripheral request is low and the words at register offsets 0x1 and 0x2 read as zero.
- R2: A write to offset 0x0 forms the command. Bit 63 set means write and clear means read. Bits 62:61 give the size: 00 byte, 01 halfword, 11 word. Bits 55:32 are the address and bits 31:0 the write data. From the cycle after an accepted command, these fields appear unchanged on the peripheral port for as long as the request is high.
- R3: Busy (status bit 48) and the request rise on the cycle after an accepted command. They fall on the cycle after the clock edge that samples acknowledge or error-acknowledge with the request high. An acknowledge while idle has no effect.
- R4: A read that ends with an acknowledge puts the peripheral read data in status bits 31:0 and sets read-data-valid (status bit 49). A write that ends with an acknowledge leaves both of these unchanged.
- R5: A transfer that ends with an error-acknowledge sets status bit 52 and the summary error (status bit 63). Read-data-valid is not set.
- R6: If no answer arrives within TIMEOUT_CYCLES cycles of request-high, the request falls after exactly that many cycles, and the timeout flag (bit 62) and the summary are set.
- R7: A command write that arrives while busy is ignored: the fields on the port do not change and the transfer goes on. It sets the overrun flag (bit 61) and the summary.
- R8: A command with the reserved size code 10 starts no transfer. It sets the bad-size flag (bit 60) and the summary.
- R9: Accepting a command clears read-data-valid and the error flags in the status word at 0x1.
- R10: The word at offset 0x2 holds sticky copies of the error flags, at the same bit positions with the summary at bit 63, across later commands. Every other bit of that word reads zero.
- R11: A write to offset 0x1 with bit 63 set clears the error flags in both status words. The same write with bit 63 clear changes nothing.
- R12: A write to offset 0x4 with bit 63 set drops the request on the next cycle and clears busy, read-data-valid and all error flags. Later acknowledges are ignored. The same write with bit 63 clear changes nothing.
- R13: Offsets other than 0x0, 0x1, 0x2 and 0x4 read as zero, and writes to them start no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 4 | Register offset for the write and for read data |
| host_wdata | input | 64 | Register write data |
| host_rdata | output | 64 | Contents of the register at host_addr |
| pb_req | output | 1 | Peripheral request, high for the life of a transfer |
| pb_wr | output | 1 | Transfer direction, 1 for write |
| pb_size | output | 2 | Transfer size code |
| pb_addr | output | 24 | Transfer byte address |
| pb_wdata | output | 32 | Write data |
| pb_rdata | input | 32 | Read data, valid with pb_ack |
| pb_ack | input | 1 | Transfer completed |
| pb_errack | input | 1 | Transfer failed |

## Verification
The hardest case to reach from the ports is the timeout, because it needs a peripheral that stays silent for the full cycle limit. The bench shrinks the limit to 16 and checks the request on the last high cycle and on the first low cycle. Overrun and abort both need a second register write to land while a transfer is held open. The bench gets there by keeping the acknowledge back and issuing the second write in the cycles between. A sweep over direction, all three legal sizes and acknowledge latencies 0 to 3 covers the normal paths, with the expected port fields and status words computed from the loop indices.

// File: rtl/rbpb_pkg.sv
package rbpb_pkg;

    localparam int HOST_AW   = 4;
    localparam int HOST_DW   = 64;
    localparam int PB_AW     = 24;
    localparam int PB_DW     = 32;
    localparam int HALF_W    = HOST_DW / 2;

    localparam logic [HOST_AW-1:0] OFS_CMD     = 4'h0;
    localparam logic [HOST_AW-1:0] OFS_STATUS  = 4'h1;
    localparam logic [HOST_AW-1:0] OFS_STICKY  = 4'h2;
    localparam logic [HOST_AW-1:0] OFS_ABORT   = 4'h4;

    // bit positions inside the upper half of a status word
    localparam int UB_SUMMARY = 31;
    localparam int UB_TMO     = 30;
    localparam int UB_OVR     = 29;
    localparam int UB_BSZ     = 28;
    localparam int UB_EAK     = 20;
    localparam int UB_RDV     = 17;
    localparam int UB_BUSY    = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_RSVD = 2'b10,
        SZ_WORD = 2'b11
    } xfer_size_e;

    typedef enum logic {
        CY_IDLE   = 1'b0,
        CY_ACTIVE = 1'b1
    } cyc_state_e;

    typedef struct packed {
        logic              is_wr;
        xfer_size_e        size;
        logic [PB_AW-1:0]  addr;
        logic [PB_DW-1:0]  wdata;
    } pb_cmd_t;

    typedef struct packed {
        logic timeout;
        logic overrun;
        logic bad_size;
        logic errack;
    } err_flags_t;

    function automatic pb_cmd_t unpack_cmd(input logic [HOST_DW-1:0] w);
        pb_cmd_t c;
        c.is_wr = w[63];
        c.size  = xfer_size_e'(w[62:61]);
        c.addr  = w[HALF_W +: PB_AW];
        c.wdata = w[PB_DW-1:0];
        return c;
    endfunction

    function automatic logic size_legal(input xfer_size_e s);
        return s != SZ_RSVD;
    endfunction

    function automatic logic [HALF_W-1:0] err_half(input err_flags_t e);
        logic [HALF_W-1:0] h;
        h             = '0;
        h[UB_TMO]     = e.timeout;
        h[UB_OVR]     = e.overrun;
        h[UB_BSZ]     = e.bad_size;
        h[UB_EAK]     = e.errack;
        h[UB_SUMMARY] = |e;
        return h;
    endfunction

    function automatic err_flags_t err_merge(input err_flags_t a, input err_flags_t b);
        return err_flags_t'(a | b);
    endfunction

endpackage

// File: rtl/rbpb_host_decode.sv
module rbpb_host_decode
    import rbpb_pkg::*;
(
    input  logic                host_wr,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic [HOST_DW-1:0]  host_wdata,
    input  logic                busy,
    output pb_cmd_t             cmd,
    output logic                accept,
    output logic                reject_busy,
    output logic                reject_size,
    output logic                err_clear,
    output logic                abort
);
    logic cmd_wr;

    always_comb begin
        cmd         = unpack_cmd(host_wdata);
        cmd_wr      = host_wr && (host_addr == OFS_CMD);
        reject_busy = cmd_wr && busy;
        reject_size = cmd_wr && !busy && !size_legal(cmd.size);
        accept      = cmd_wr && !busy && size_legal(cmd.size);
        err_clear   = host_wr && (host_addr == OFS_STATUS) && host_wdata[HOST_DW-1];
        abort       = host_wr && (host_addr == OFS_ABORT)  && host_wdata[HOST_DW-1];
    end

    // a command write has exactly one outcome
    always_comb begin
        a_one_outcome_r7: assert ($countones({accept, reject_busy, reject_size}) == int'(cmd_wr));
    end

endmodule

// File: rtl/rbpb_cycle_fsm.sv
module rbpb_cycle_fsm
    import rbpb_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1200
)(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept,
    input  logic     abort,
    input  pb_cmd_t  cmd_in,
    input  logic     pb_ack,
    input  logic     pb_errack,
    output logic     busy,
    output pb_cmd_t  cmd_q,
    output logic     term_ack,
    output logic     term_eak,
    output logic     term_tmo
);
    localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    cyc_state_e       state;
    logic [CNT_W-1:0] wait_cnt;
    logic             active_live;

    assign busy        = (state == CY_ACTIVE);
    assign active_live = busy && !abort;

    always_comb begin
        term_eak = active_live && pb_errack;
        term_ack = active_live && pb_ack && !pb_errack;
        term_tmo = active_live && !pb_ack && !pb_errack && (wait_cnt == CNT_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= CY_IDLE;
            cmd_q    <= '0;
            wait_cnt <= '0;
        end else if (abort) begin
            state    <= CY_IDLE;
            wait_cnt <= '0;
        end else begin
            unique case (state)
                CY_IDLE: begin
                    if (accept) begin
                        state    <= CY_ACTIVE;
                        cmd_q    <= cmd_in;
                        wait_cnt <= '0;
                    end
                end
                CY_ACTIVE: begin
                    if (term_ack || term_eak || term_tmo) begin
                        state    <= CY_IDLE;
                        wait_cnt <= '0;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                default: state <= CY_IDLE;
            endcase
        end
    end

    p_timer_bound_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (wait_cnt <= CNT_LAST));

    p_timeout_ends_r6: assert property (@(posedge clk) disable iff (rst)
        term_tmo |=> !busy);

    p_one_ending_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({term_ack, term_eak, term_tmo}));

endmodule

// File: rtl/rbpb_status_regs.sv
module rbpb_status_regs
    import rbpb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic                reject_busy,
    input  logic                reject_size,
    input  logic                err_clear,
    input  logic                abort,
    input  logic                term_eak,
    input  logic                term_tmo,
    input  logic                rd_ok,
    input  logic [PB_DW-1:0]    rd_data,
    input  logic                busy,
    output logic [HOST_DW-1:0]  live_word,
    output logic [HOST_DW-1:0]  sticky_word
);
    err_flags_t        live_err;
    err_flags_t        sticky_err;
    err_flags_t        new_err;
    logic              rdv;
    logic [PB_DW-1:0]  rdata_q;

    always_comb begin
        new_err.timeout  = term_tmo;
        new_err.overrun  = reject_busy;
        new_err.bad_size = reject_size;
        new_err.errack   = term_eak;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_err   <= '0;
            sticky_err <= '0;
            rdv        <= 1'b0;
            rdata_q    <= '0;
        end else if (abort) begin
            live_err   <= '0;
            sticky_err <= '0;
            rdv        <= 1'b0;
        end else begin
            if (accept || err_clear) live_err <= new_err;
            else                     live_err <= err_merge(live_err, new_err);

            if (err_clear) sticky_err <= new_err;
            else           sticky_err <= err_merge(sticky_err, new_err);

            if (accept)     rdv <= 1'b0;
            else if (rd_ok) rdv <= 1'b1;

            if (rd_ok) rdata_q <= rd_data;
        end
    end

    always_comb begin
        logic [HALF_W-1:0] up;
        up           = err_half(live_err);
        up[UB_RDV]   = rdv;
        up[UB_BUSY]  = busy;
        live_word    = {up, rdata_q};
        sticky_word  = {err_half(sticky_err), {HALF_W{1'b0}}};
    end

    p_overrun_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (reject_busy && !abort) |=> (live_word[HALF_W + UB_OVR] && live_word[HOST_DW-1]));

    p_bad_size_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (reject_size && !abort) |=> live_word[HALF_W + UB_BSZ]);

    p_rdv_clear_r9: assert property (@(posedge clk) disable iff (rst)
        accept |=> !live_word[HALF_W + UB_RDV]);

    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (sticky_err.timeout && !err_clear && !abort) |=> sticky_err.timeout);

    p_abort_clear_r12: assert property (@(posedge clk) disable iff (rst)
        abort |=> (sticky_word == '0 && live_word[HOST_DW-1:HALF_W] == '0));

endmodule

// File: rtl/rb_pbus_bridge.sv
module rb_pbus_bridge
    import rbpb_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1200
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                host_wr,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic [HOST_DW-1:0]  host_wdata,
    output logic [HOST_DW-1:0]  host_rdata,
    output logic                pb_req,
    output logic                pb_wr,
    output logic [1:0]          pb_size,
    output logic [PB_AW-1:0]    pb_addr,
    output logic [PB_DW-1:0]    pb_wdata,
    input  logic [PB_DW-1:0]    pb_rdata,
    input  logic                pb_ack,
    input  logic                pb_errack
);
    pb_cmd_t            dec_cmd;
    pb_cmd_t            cur_cmd;
    logic               accept, reject_busy, reject_size, err_clear, abort;
    logic               busy, term_ack, term_eak, term_tmo, rd_ok;
    logic [HOST_DW-1:0] live_word, sticky_word;

    rbpb_host_decode u_decode (
        .host_wr     (host_wr),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .busy        (busy),
        .cmd         (dec_cmd),
        .accept      (accept),
        .reject_busy (reject_busy),
        .reject_size (reject_size),
        .err_clear   (err_clear),
        .abort       (abort)
    );

    rbpb_cycle_fsm #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .abort     (abort),
        .cmd_in    (dec_cmd),
        .pb_ack    (pb_ack),
        .pb_errack (pb_errack),
        .busy      (busy),
        .cmd_q     (cur_cmd),
        .term_ack  (term_ack),
        .term_eak  (term_eak),
        .term_tmo  (term_tmo)
    );

    assign rd_ok = term_ack && !cur_cmd.is_wr;

    rbpb_status_regs u_status (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .reject_busy (reject_busy),
        .reject_size (reject_size),
        .err_clear   (err_clear),
        .abort       (abort),
        .term_eak    (term_eak),
        .term_tmo    (term_tmo),
        .rd_ok       (rd_ok),
        .rd_data     (pb_rdata),
        .busy        (busy),
        .live_word   (live_word),
        .sticky_word (sticky_word)
    );

    always_comb begin
        pb_req   = busy;
        pb_wr    = cur_cmd.is_wr;
        pb_size  = cur_cmd.size;
        pb_addr  = cur_cmd.addr;
        pb_wdata = cur_cmd.wdata;
    end

    always_comb begin
        unique case (host_addr)
            OFS_STATUS: host_rdata = live_word;
            OFS_STICKY: host_rdata = sticky_word;
            default:    host_rdata = '0;
        endcase
    end

    p_start_r3: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == OFS_CMD && !pb_req && host_wdata[62:61] != 2'b10) |=> pb_req);

    p_end_r3: assert property (@(posedge clk) disable iff (rst)
        (pb_req && (pb_ack || pb_errack)) |=> !pb_req);

    p_fields_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (pb_req && $past(pb_req)) |-> ($stable(pb_addr) && $stable(pb_wdata) && $stable(pb_wr) && $stable(pb_size)));

    p_abort_drop_r12: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == OFS_ABORT && host_wdata[63]) |=> !pb_req);

endmodule

// File: tb/sim_rb_pbus_bridge.sv
module sim_rb_pbus_bridge;
    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [3:0]  host_addr = 4'h0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic        pb_req, pb_wr;
    logic [1:0]  pb_size;
    logic [23:0] pb_addr;
    logic [31:0] pb_wdata;
    logic [31:0] pb_rdata = '0;
    logic        pb_ack = 1'b0;
    logic        pb_errack = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rb_pbus_bridge #(.TIMEOUT_CYCLES(TMO)) u0 (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .pb_req(pb_req),
        .pb_wr(pb_wr), .pb_size(pb_size), .pb_addr(pb_addr), .pb_wdata(pb_wdata),
        .pb_rdata(pb_rdata), .pb_ack(pb_ack), .pb_errack(pb_errack)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [3:0] a, input logic [63:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic hread(input logic [3:0] a, output logic [63:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic ack_now(input logic [31:0] rd);
        pb_ack = 1'b1; pb_rdata = rd;
        @(negedge clk);
        pb_ack = 1'b0; pb_rdata = '0;
    endtask

    function automatic logic [63:0] mkcmd(input logic w, input logic [1:0] sz,
                                          input logic [23:0] a, input logic [31:0] d);
        return {w, sz, 5'b0, a, d};
    endfunction

    initial begin
        logic [63:0] v;
        logic [31:0] last_rd;
        last_rd = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 req", {63'b0, pb_req}, 64'h0);
        hread(4'h1, v); chk("R1 status", v, 64'h0);
        hread(4'h2, v); chk("R1 sticky", v, 64'h0);

        // sweep: direction x legal size x ack latency
        for (int d = 0; d < 2; d++) begin
            for (int si = 0; si < 3; si++) begin
                for (int lat = 0; lat < 4; lat++) begin
                    int k;
                    logic [1:0]  sz;
                    logic [23:0] a;
                    logic [31:0] wd;
                    k  = d * 12 + si * 4 + lat;
                    sz = (si == 0) ? 2'b00 : (si == 1) ? 2'b01 : 2'b11;
                    a  = 24'(k * 32'h000A0B1 + 5);
                    wd = 32'hC0DE0000 ^ (32'(k) * 32'h01010101);
                    hwrite(4'h0, mkcmd(d[0], sz, a, wd));
                    chk("R2 port fields", {27'b0, pb_req, pb_wr, pb_size, pb_addr, pb_wdata},
                        {27'b0, 1'b1, d[0], sz, a, wd});
                    hread(4'h1, v);
                    chk("R3/R9 busy, rdv cleared", v, {32'h0001_0000, last_rd});
                    for (int i = 0; i < lat; i++) begin
                        @(negedge clk);
                        chk("R2 hold", {39'b0, pb_req, pb_addr}, {39'b0, 1'b1, a});
                    end
                    ack_now(~wd);
                    if (d == 0) last_rd = ~wd;
                    hread(4'h1, v);
                    chk("R4 completion", v, {(d == 0) ? 32'h0002_0000 : 32'h0, last_rd});
                    chk("R3 req low", {63'b0, pb_req}, 64'h0);
                end
            end
        end

        // R5 error-acknowledge on a read
        hwrite(4'h0, mkcmd(1'b0, 2'b11, 24'h00ABCD, 32'h0));
        @(negedge clk);
        pb_errack = 1'b1;
        @(negedge clk);
        pb_errack = 1'b0;
        hread(4'h1, v); chk("R5 errack status", v, {32'h8010_0000, last_rd});
        hread(4'h2, v); chk("R10 sticky errack", v, 64'h8010_0000_0000_0000);

        // R9/R10 new command clears live errors, sticky holds
        hwrite(4'h0, mkcmd(1'b1, 2'b00, 24'h000001, 32'h5A));
        ack_now(32'h0);
        hread(4'h1, v); chk("R9 live cleared", v, {32'h0, last_rd});
        hread(4'h2, v); chk("R10 sticky kept", v, 64'h8010_0000_0000_0000);

        // R11 clear
        hwrite(4'h1, 64'h7FFF_FFFF_FFFF_FFFF);
        hread(4'h2, v); chk("R11 no-op clear", v, 64'h8010_0000_0000_0000);
        hwrite(4'h1, 64'h8000_0000_0000_0000);
        hread(4'h2, v); chk("R11 clear", v, 64'h0);

        // R6 timeout
        hwrite(4'h0, mkcmd(1'b0, 2'b01, 24'h123456, 32'h0));
        repeat (TMO - 1) @(negedge clk);
        chk("R6 req on last cycle", {63'b0, pb_req}, 64'h1);
        @(negedge clk);
        chk("R6 req dropped", {63'b0, pb_req}, 64'h0);
        hread(4'h1, v); chk("R6 timeout status", v, {32'hC000_0000, last_rd});
        hread(4'h2, v); chk("R10 sticky timeout", v, 64'hC000_0000_0000_0000);
        ack_now(32'hDEADBEEF);
        hread(4'h1, v); chk("R3 idle ack ignored", v, {32'hC000_0000, last_rd});
        hwrite(4'h1, 64'h8000_0000_0000_0000);

        // R7 overrun
        hwrite(4'h0, mkcmd(1'b1, 2'b11, 24'h0000AA, 32'h11112222));
        hwrite(4'h0, mkcmd(1'b0, 2'b00, 24'h0000BB, 32'h33334444));
        chk("R7 fields kept", {7'b0, pb_req, pb_wr, pb_addr, pb_wdata},
            {7'b0, 1'b1, 1'b1, 24'h0000AA, 32'h11112222});
        hread(4'h1, v); chk("R7 overrun while busy", v, {32'hA001_0000, last_rd});
        ack_now(32'h0);
        hread(4'h1, v); chk("R7 overrun after end", v, {32'hA000_0000, last_rd});
        hwrite(4'h1, 64'h8000_0000_0000_0000);

        // R8 reserved size
        hwrite(4'h0, mkcmd(1'b1, 2'b10, 24'h000010, 32'h0));
        chk("R8 no request", {63'b0, pb_req}, 64'h0);
        hread(4'h1, v); chk("R8 bad size status", v, {32'h9000_0000, last_rd});

        // R12 abort
        hwrite(4'h0, mkcmd(1'b0, 2'b11, 24'h00C0C0, 32'h0));
        @(negedge clk);
        hwrite(4'h4, 64'h7FFF_FFFF_FFFF_FFFF);
        chk("R12 no-op abort", {63'b0, pb_req}, 64'h1);
        hwrite(4'h4, 64'h8000_0000_0000_0000);
        chk("R12 abort drops req", {63'b0, pb_req}, 64'h0);
        hread(4'h1, v); chk("R12 status cleared", v, {32'h0, last_rd});
        hread(4'h2, v); chk("R12 sticky cleared", v, 64'h0);
        ack_now(32'h0BADF00D);
        hread(4'h1, v); chk("R12 late ack ignored", v, {32'h0, last_rd});

        // R13 unused offsets
        for (int a = 3; a < 16; a++) begin
            if (a != 4) begin
                hread(4'(a), v);
                chk("R13 unused read", v, 64'h0);
            end
        end
        hwrite(4'h3, mkcmd(1'b1, 2'b11, 24'h000777, 32'h1));
        chk("R13 unused write", {63'b0, pb_req}, 64'h0);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule